// File: doc/BRIEF.md
# Interlocked Asynchronous Bus Register Slave

This block lets a small bank of 16-bit registers answer transfers on a fully asynchronous, interlocked system bus. The bus has an 18-bit byte address and a 16-bit data path. A master puts address, cycle code and write data on the bus and then raises its strobe. The slave completes the transfer and answers with its own acknowledge. It keeps the acknowledge high until the master drops the strobe. Because the slave sets the pace, fast and slow devices can share one bus.

The block runs on its own local clock. Every bus input passes through a two-flop synchronizer. Address, cycle code and data are captured only after the synchronized strobe is seen high. The register bank sits inside the I/O window that fills the top 8 KB of the address space. Any address that does not land on a register gets no acknowledge, so the master's own timeout ends the cycle.

Four cycle types are decoded. These are a word read, a read that opens a read-modify-write, a word write and a byte write. A read-modify-write reserves its register until the closing write arrives or the bus is re-initialised.

Top module: `async_bus_slave`

## Requirements
- R1: After reset, the acknowledge and the read-data enable are low, and every register reads back as 0.
- R2: The cycle code selects the transfer: 00 is a word read, 01 is a read that opens a read-modify-write, 10 is a word write and 11 is a byte write. On either read type, the slave drives the addressed register on the data outputs with the enable high, and only after that does it raise the acknowledge.
- R3: A word write replaces all 16 bits of the addressed register.
- R4: A byte write uses address bit 0 to pick the lane: 0 writes data bits 7:0 and 1 writes data bits 15:8. The other byte keeps its value.
- R5: Once raised, the acknowledge stays high while the master strobe is high. It falls within 8 clock cycles of the strobe falling, and it rises only while the strobe is high.
- R6: Registers sit at word addresses REG_BASE + 2*i for i below NUM_REGS, and bit 0 of the address is ignored when a register is decoded. An address outside the top 8 KB, or inside it but not on a register, never raises the acknowledge and changes no register.
- R7: A read-modify-write read returns the register value like a plain read and reserves that register.
- R8: While a register is reserved, a read-modify-write read of any other register gets no acknowledge. Plain reads and writes to any register are still served.
- R9: A word or byte write to the reserved register releases the reservation. The bus init input also releases it and clears every register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock of the slave |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_init | input | 1 | Bus initialise; clears registers and reservation (asynchronous, synchronized) |
| msync_a | input | 1 | Master strobe from the bus (asynchronous) |
| addr_a | input | 18 | Byte address from the bus |
| ctl_a | input | 2 | Cycle code from the bus |
| wdata_a | input | 16 | Write data from the bus |
| ssync | output | 1 | Slave acknowledge |
| rdata | output | 16 | Read data |
| rdata_oe | output | 1 | Read data valid / drive enable |

## Verification
The checker watches the handshake interlock on every cycle. The acknowledge rises only under a live strobe, holds while the strobe is high and drops once the strobe is gone. During a read the data enable stays high for as long as the acknowledge is up. Every miss and every rejected read-modify-write leaves the acknowledge low and writes nothing. The register contents tell apart the byte lanes, word writes, the reservation across a read-modify-write and the effect of the bus init. These contents are visible only through bus reads, so the bench's mixed random and directed scenarios are what show them, checked against a reference model of the register bank.

// File: rtl/async_bus_slave_pkg.sv
package async_bus_slave_pkg;

  typedef enum logic [1:0] {
    CYC_READ = 2'b00,
    CYC_RMW  = 2'b01,
    CYC_WORD = 2'b10,
    CYC_BYTE = 2'b11
  } cyc_e;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_EXEC  = 2'd1,
    HS_ACK   = 2'd2,
    HS_NOACK = 2'd3
  } hs_state_e;

endpackage

// File: rtl/abs_sync.sv
module abs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/abs_decode.sv
module abs_decode #(
  parameter int              ADDR_W   = 18,
  parameter int              REGION_W = 13,
  parameter int              NUM_REGS = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 18'h3FF00,
  localparam int             IDX_W    = $clog2(NUM_REGS),
  localparam int             WA_W     = ADDR_W - 1
) (
  input  logic [WA_W-1:0]  word_addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  localparam logic [WA_W-1:0] BASE_W = REG_BASE[ADDR_W-1:1];

  logic [WA_W-1:0] offset;
  logic            in_region;
  logic            above_base;
  logic            in_bank;

  always_comb begin
    offset     = word_addr - BASE_W;
    in_region  = &word_addr[WA_W-1:REGION_W-1];
    above_base = (word_addr >= BASE_W);
    in_bank    = (offset < WA_W'(NUM_REGS));
    hit        = in_region && above_base && in_bank;
    idx        = offset[IDX_W-1:0];
  end

endmodule

// File: rtl/abs_regfile.sv
module abs_regfile #(
  parameter int  DATA_W   = 16,
  parameter int  NUM_REGS = 8,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int LANES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [NUM_REGS-1:0][DATA_W-1:0] bank;

  for (genvar i = 0; i < NUM_REGS; i++) begin : gen_reg
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] q_d;
    logic              sel;

    assign sel = (wr_idx == IDX_W'(i));

    always_comb begin
      q_d = q;
      if (clr) begin
        q_d = '0;
      end else if (sel) begin
        for (int b = 0; b < LANES; b++) begin
          if (wr_be[b]) q_d[b*8 +: 8] = wr_data[b*8 +: 8];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_d;
    end

    assign bank[i] = q;
  end

  assign rd_data = bank[rd_idx];

endmodule

// File: rtl/abs_ctrl.sv
module abs_ctrl
  import async_bus_slave_pkg::*;
#(
  parameter int  ADDR_W   = 18,
  parameter int  DATA_W   = 16,
  parameter int  NUM_REGS = 8,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int LANES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_s,
  input  logic              msync_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [1:0]        ctl_s,
  input  logic [DATA_W-1:0] wdata_s,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] cap_addr,
  output cyc_e              cap_ctl,
  output logic [DATA_W-1:0] cap_data,
  output logic [LANES-1:0]  wr_be,
  output logic              in_exec,
  output logic              lock_q,
  output logic [IDX_W-1:0]  lock_idx_q,
  output logic              ssync,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);

  hs_state_e         state_q, state_d;
  logic              cap_en;
  logic              accept;
  logic              is_rd;
  logic              is_wr;
  logic              lock_d;
  logic [IDX_W-1:0]  lock_idx_d;
  logic [DATA_W-1:0] rdata_d;
  logic              oe_d;
  logic              ssync_d;

  assign in_exec = (state_q == HS_EXEC);
  assign is_rd   = (cap_ctl == CYC_READ) || (cap_ctl == CYC_RMW);
  assign is_wr   = !is_rd;
  assign accept  = hit && !((cap_ctl == CYC_RMW) && lock_q && (idx != lock_idx_q));

  // next state
  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    unique case (state_q)
      HS_IDLE: begin
        if (msync_s) begin
          cap_en  = 1'b1;
          state_d = HS_EXEC;
        end
      end
      HS_EXEC:  state_d = accept ? HS_ACK : HS_NOACK;
      HS_ACK:   if (!msync_s) state_d = HS_IDLE;
      HS_NOACK: if (!msync_s) state_d = HS_IDLE;
      default:  state_d = HS_IDLE;
    endcase
    if (init_s) begin
      state_d = HS_IDLE;
      cap_en  = 1'b0;
    end
  end

  // write strobes
  always_comb begin
    wr_be = '0;
    if (in_exec && accept && !init_s) begin
      if (cap_ctl == CYC_WORD)      wr_be = '1;
      else if (cap_ctl == CYC_BYTE) wr_be = cap_addr[0] ? LANES'(2'b10) : LANES'(2'b01);
    end
  end

  // reservation, read data, acknowledge
  always_comb begin
    lock_d     = lock_q;
    lock_idx_d = lock_idx_q;
    rdata_d    = rdata;
    oe_d       = rdata_oe;
    if (in_exec && accept) begin
      if (cap_ctl == CYC_RMW) begin
        lock_d     = 1'b1;
        lock_idx_d = idx;
      end else if (is_wr && lock_q && (idx == lock_idx_q)) begin
        lock_d = 1'b0;
      end
      if (is_rd) begin
        rdata_d = rd_word;
        oe_d    = 1'b1;
      end
    end
    if ((state_q == HS_ACK) && !msync_s) oe_d = 1'b0;
    ssync_d = (state_q == HS_ACK) && (state_d == HS_ACK);
    if (init_s) begin
      lock_d  = 1'b0;
      oe_d    = 1'b0;
      ssync_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= HS_IDLE;
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
      rdata      <= '0;
      rdata_oe   <= 1'b0;
      ssync      <= 1'b0;
    end else begin
      state_q    <= state_d;
      lock_q     <= lock_d;
      lock_idx_q <= lock_idx_d;
      rdata      <= rdata_d;
      rdata_oe   <= oe_d;
      ssync      <= ssync_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_ctl  <= CYC_READ;
      cap_data <= '0;
    end else if (cap_en) begin
      cap_addr <= addr_s;
      cap_ctl  <= cyc_e'(ctl_s);
      cap_data <= wdata_s;
    end
  end

endmodule

// File: rtl/async_bus_slave.sv
module async_bus_slave
  import async_bus_slave_pkg::*;
#(
  parameter int                ADDR_W   = 18,
  parameter int                DATA_W   = 16,
  parameter int                REGION_W = 13,
  parameter int                NUM_REGS = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 18'h3FF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_init,
  input  logic              msync_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [1:0]        ctl_a,
  input  logic [DATA_W-1:0] wdata_a,
  output logic              ssync,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);

  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int LANES = DATA_W / 8;
  localparam int SYN_W = 2 + ADDR_W + 2 + DATA_W;

  logic              rst_meta_q, rst_n_s;
  logic              init_s, msync_s;
  logic [ADDR_W-1:0] addr_s;
  logic [1:0]        ctl_s;
  logic [DATA_W-1:0] wdata_s;
  logic [ADDR_W-1:0] cap_addr;
  cyc_e              cap_ctl;
  logic [DATA_W-1:0] cap_data;
  logic [LANES-1:0]  wr_be;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rd_word;
  logic              in_exec;
  logic              lock_q;
  logic [IDX_W-1:0]  lock_idx_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  abs_sync #(.W(SYN_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     ({bus_init, msync_a, addr_a, ctl_a, wdata_a}),
    .q     ({init_s, msync_s, addr_s, ctl_s, wdata_s})
  );

  abs_decode #(
    .ADDR_W   (ADDR_W),
    .REGION_W (REGION_W),
    .NUM_REGS (NUM_REGS),
    .REG_BASE (REG_BASE)
  ) u_decode (
    .word_addr (cap_addr[ADDR_W-1:1]),
    .hit       (hit),
    .idx       (idx)
  );

  abs_regfile #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr     (init_s),
    .wr_idx  (idx),
    .wr_be   (wr_be),
    .wr_data (cap_data),
    .rd_idx  (idx),
    .rd_data (rd_word)
  );

  abs_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .init_s     (init_s),
    .msync_s    (msync_s),
    .addr_s     (addr_s),
    .ctl_s      (ctl_s),
    .wdata_s    (wdata_s),
    .hit        (hit),
    .idx        (idx),
    .rd_word    (rd_word),
    .cap_addr   (cap_addr),
    .cap_ctl    (cap_ctl),
    .cap_data   (cap_data),
    .wr_be      (wr_be),
    .in_exec    (in_exec),
    .lock_q     (lock_q),
    .lock_idx_q (lock_idx_q),
    .ssync      (ssync),
    .rdata      (rdata),
    .rdata_oe   (rdata_oe)
  );

endmodule

// File: rtl/async_bus_slave_checker.sv
module async_bus_slave_checker
  import async_bus_slave_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             init_s,
  input logic             msync_s,
  input logic             ssync,
  input logic             rdata_oe,
  input logic             in_exec,
  input cyc_e             cap_ctl,
  input logic             hit,
  input logic [IDX_W-1:0] idx,
  input logic             lock_q,
  input logic [IDX_W-1:0] lock_idx_q,
  input logic [LANES-1:0] wr_be
);

  AST_ACK_RISES_UNDER_STROBE: assert property (@(posedge clk) disable iff (!rst_n_s || init_s)
    $rose(ssync) |-> msync_s);  // R5

  AST_ACK_HELD_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n_s || init_s)
    (ssync && msync_s) |=> ssync);  // R5

  AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n_s || init_s)
    (ssync && !msync_s) |=> !ssync);  // R5

  AST_READ_DATA_UNDER_ACK: assert property (@(posedge clk) disable iff (!rst_n_s || init_s)
    (ssync && ((cap_ctl == CYC_READ) || (cap_ctl == CYC_RMW))) |-> rdata_oe);  // R2

  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n_s || init_s)
    (in_exec && !hit) |-> (wr_be == '0));  // R6

  AST_MISS_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n_s || init_s)
    (in_exec && !hit) |-> ##2 !ssync);  // R6

  AST_LOCK_REJECT: assert property (@(posedge clk) disable iff (!rst_n_s || init_s)
    (in_exec && hit && lock_q && (cap_ctl == CYC_RMW) && (idx != lock_idx_q)) |-> ##2 !ssync);  // R8

endmodule

bind async_bus_slave async_bus_slave_checker #(
  .IDX_W ($clog2(NUM_REGS)),
  .LANES (DATA_W / 8)
) u_checker (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .init_s     (init_s),
  .msync_s    (msync_s),
  .ssync      (ssync),
  .rdata_oe   (rdata_oe),
  .in_exec    (in_exec),
  .cap_ctl    (cap_ctl),
  .hit        (hit),
  .idx        (idx),
  .lock_q     (lock_q),
  .lock_idx_q (lock_idx_q),
  .wr_be      (wr_be)
);

// File: tb/async_bus_slave_bench.sv
`timescale 1ns/1ps
module async_bus_slave_bench;

  localparam int          NREG = 8;
  localparam logic [17:0] BASE = 18'h3FF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_init = 1'b0;
  logic        msync_a = 1'b0;
  logic [17:0] addr_a = '0;
  logic [1:0]  ctl_a = '0;
  logic [15:0] wdata_a = '0;
  logic        ssync;
  logic [15:0] rdata;
  logic        rdata_oe;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [NREG];
  bit          m_lock = 1'b0;
  int          m_lidx = 0;

  always #10 clk = ~clk;

  async_bus_slave u_async_bus_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_init (bus_init),
    .msync_a  (msync_a),
    .addr_a   (addr_a),
    .ctl_a    (ctl_a),
    .wdata_a  (wdata_a),
    .ssync    (ssync),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_hit(input logic [17:0] a);
    logic [16:0] w, b;
    w = a[17:1];
    b = BASE[17:1];
    return (a[17:13] == 5'h1F) && (w >= b) && ((w - b) < 17'(NREG));
  endfunction

  function automatic int reg_of(input logic [17:0] a);
    logic [16:0] d;
    d = a[17:1] - BASE[17:1];
    return int'(d);
  endfunction

  function automatic bit exp_ack(input logic [17:0] a, input logic [1:0] c);
    if (!is_hit(a)) return 1'b0;
    if (c == 2'b01 && m_lock && reg_of(a) != m_lidx) return 1'b0;
    return 1'b1;
  endfunction

  // one master transfer with the interlocked handshake
  task automatic xfer(input logic [17:0] a, input logic [1:0] c, input logic [15:0] d,
                      input string req, output bit ack, output logic [15:0] rd);
    bit rel;
    ack = 1'b0;
    rd  = '0;
    @(negedge clk);
    addr_a = a; ctl_a = c; wdata_a = d;
    @(negedge clk);
    msync_a = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (ssync) begin ack = 1'b1; break; end
    end
    if (ack) begin
      rd = rdata;
      if (c[1] == 1'b0) check(rdata_oe === 1'b1, {req, " R2 data enable with ack"}, rdata_oe, 1);
      repeat (3) @(negedge clk);
      check(ssync === 1'b1, "R5 ack held while strobe high", ssync, 1);
    end
    msync_a = 1'b0;
    rel = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!ssync) begin rel = 1'b1; break; end
    end
    check(rel, "R5 ack released after strobe", ssync, 0);
    repeat (4) @(negedge clk);
  endtask

  // transfer checked against the reference model, model then updated
  task automatic mxfer(input logic [17:0] a, input logic [1:0] c, input logic [15:0] d, input string req);
    bit          ack, e;
    logic [15:0] rd;
    int          r;
    e = exp_ack(a, c);
    xfer(a, c, d, req, ack, rd);
    check(ack == e, {req, " ack"}, ack, e);
    if (e) begin
      r = reg_of(a);
      case (c)
        2'b00: check(rd === model[r], {req, " R2 read data"}, rd, model[r]);
        2'b01: begin
          check(rd === model[r], {req, " R7 rmw read data"}, rd, model[r]);
          m_lock = 1'b1; m_lidx = r;
        end
        2'b10: begin
          model[r] = d;
          if (m_lock && m_lidx == r) m_lock = 1'b0;
        end
        default: begin
          if (a[0]) model[r][15:8] = d[15:8];
          else      model[r][7:0]  = d[7:0];
          if (m_lock && m_lidx == r) m_lock = 1'b0;
        end
      endcase
    end
  endtask

  task automatic pulse_init();
    @(negedge clk);
    bus_init = 1'b1;
    repeat (3) @(negedge clk);
    bus_init = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NREG; i++) model[i] = '0;
    m_lock = 1'b0;
  endtask

  function automatic logic [17:0] ra(input int i);
    return BASE + 18'(2 * i);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [17:0] a;
    logic [1:0]  c;
    int          pick;
    bit          dummy_ack;
    logic [15:0] dummy_rd;
    void'($urandom(32'd2024));
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(ssync === 1'b0, "R1 ack low after reset", ssync, 0);
    check(rdata_oe === 1'b0, "R1 data enable low after reset", rdata_oe, 0);
    for (int i = 0; i < NREG; i++) mxfer(ra(i), 2'b00, 16'h0, "R1 reset value");

    // R3 word write, R2 read back
    mxfer(ra(3), 2'b10, 16'hA5C3, "R3 word write");
    mxfer(ra(3), 2'b00, 16'h0, "R3 word read back");
    mxfer(ra(3) | 18'h1, 2'b00, 16'h0, "R6 bit0 ignored on read");

    // R4 byte lanes
    mxfer(ra(3), 2'b11, 16'h1177, "R4 low lane write");
    mxfer(ra(3), 2'b00, 16'h0, "R4 low lane read");
    mxfer(ra(3) | 18'h1, 2'b11, 16'h99EE, "R4 high lane write");
    mxfer(ra(3), 2'b00, 16'h0, "R4 high lane read");
    check(model[3] == 16'h9977, "R4 lanes merged in model", model[3], 16'h9977);

    // R6 misses: outside window, in window below base, just past the bank
    mxfer(18'h01000, 2'b10, 16'hDEAD, "R6 outside window");
    mxfer(18'h3E000, 2'b10, 16'hDEAD, "R6 in window unmapped");
    mxfer(ra(NREG), 2'b10, 16'hDEAD, "R6 past bank");
    mxfer(BASE - 18'd2, 2'b00, 16'h0, "R6 below base");
    for (int i = 0; i < NREG; i++) mxfer(ra(i), 2'b00, 16'h0, "R6 no register changed");

    // R7 R8 R9 read-modify-write reservation
    mxfer(ra(5), 2'b01, 16'h0, "R7 rmw open");
    mxfer(ra(2), 2'b01, 16'h0, "R8 rmw other reg rejected");
    mxfer(ra(2), 2'b00, 16'h0, "R8 plain read other reg");
    mxfer(ra(2), 2'b10, 16'h1234, "R8 write other reg");
    mxfer(ra(5), 2'b01, 16'h0, "R7 rmw same reg again");
    mxfer(ra(5), 2'b10, 16'h5555, "R9 closing word write");
    mxfer(ra(2), 2'b01, 16'h0, "R9 rmw after release");
    mxfer(ra(2) | 18'h1, 2'b11, 16'hC000, "R9 closing byte write");
    mxfer(ra(6), 2'b01, 16'h0, "R9 rmw after byte release");
    mxfer(ra(1), 2'b01, 16'h0, "R8 still reserved");

    // R9 bus init clears registers and reservation
    pulse_init();
    mxfer(ra(1), 2'b01, 16'h0, "R9 rmw after init");
    for (int i = 0; i < NREG; i++) mxfer(ra(i), 2'b00, 16'h0, "R9 cleared by init");

    // random mix
    for (int n = 0; n < 300; n++) begin
      pick = int'($urandom_range(0, 9));
      if (pick < 6)      a = ra(int'($urandom_range(0, NREG - 1))) | 18'($urandom_range(0, 1));
      else if (pick < 8) a = 18'h3E000 + 18'($urandom_range(0, 18'h1EFF));
      else               a = 18'($urandom_range(0, 18'h3DFFF));
      c = 2'($urandom_range(0, 3));
      mxfer(a, c, 16'($urandom), "R2 random mix");
      if (n == 150) pulse_init();
    end
    for (int i = 0; i < NREG; i++) mxfer(ra(i), 2'b00, 16'h0, "R3 final contents");

    xfer(ra(0), 2'b00, 16'h0, "R2 last", dummy_ack, dummy_rd);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule